// File: doc/BRIEF.md
# Buffered Timer Time-Base

A 16-bit timer time-base: a counter driven by a programmable clock divider, compared against a reload limit that sets its period. The counter can run upward, downward, or bounce between the two ends (center-aligned). Software reaches the control word, the live count, the divider ratio and the reload limit through a single-cycle write port and a combinational read port. The count can be written while the timer is running.

The reload limit is held in a buffer register. A control bit picks when the buffer reaches the working (shadow) copy: every clock, or only at an update event. The divider ratio is always buffered and changes only at an update event. An update event comes from a wrap at either end of the count, unless the update-mute bit is set. Software can also force one with a generate command. A forced event clears the divider and restarts the count. Each event produces a one-cycle pulse and sets a sticky flag, which software clears.

Inside, the counter is a two-state direction machine. ST_RISE counts toward the limit, and ST_FALL counts toward zero. In up mode the machine sits in ST_RISE and in down mode it sits in ST_FALL. In center mode it moves ST_RISE→ST_FALL on reaching the limit (overflow) and ST_FALL→ST_RISE on reaching zero (underflow). A forced update sends it to ST_FALL in down mode and to ST_RISE otherwise.

Top module: `tbu_timebase`

## Requirements
- R1: After reset the count is 0, the pulse and flag are 0, the reload limit reads all ones and the divider ratio reads 0.
- R2: The internal enable follows the run bit (control bit 0) one clock late, so the first count change appears two clocks after the write cycle that sets it.
- R3: In up mode (control bits 4:3 = 0), the count steps 0,1,…,L and then returns to 0, where L is the working reload limit. The tick that returns it to 0 gives an overflow event, so the period is L+1 ticks.
- R4: In down mode (mode 1), the count steps down to 0. The next tick loads L and gives an underflow event.
- R5: In center mode (mode 2), the count rises to L with an overflow event on reaching it, then falls to 0 with an underflow event on reaching it, so one period is 2L ticks.
- R6: With divider value P (address 2), one tick occurs every P+1 clocks. A newly written P takes effect only after the next update event.
- R7: With reload-buffer-enable (control bit 2) clear, a value written to the reload address (3) is used from the next cycle. With it set, the written value is used only after the next update event.
- R8: While update-mute (control bit 1) is set, a wrap raises neither the pulse nor the flag, and the counter still wraps.
- R9: Writing 1 in bit 0 to the generate address (5) raises an update even while muted. It clears the divider and restarts the count at 0 (up and center) or at the buffered reload value (down).
- R10: Each update event raises `update_pulse` for one cycle and sets `update_flag`. The flag stays set until any write to the flag address (4).
- R11: The count (address 1) can be written while running and the write overrides that cycle's tick. Reads at addresses 0 to 4 return the control word, count, divider buffer, reload buffer and flag (bit 0).
- R12: Clearing the run bit stops the count after the one-clock enable lag, and the count then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| count_val | output | 16 | Current count |
| update_pulse | output | 1 | One-cycle update event pulse |
| update_flag | output | 1 | Sticky update flag |

## Verification
The bench checks that the first count change comes exactly two clocks after the run write. A design without the enable lag shows 1 one cycle early. It writes a new divider and a new reload limit while buffering is on and watches the old values stay in force until the wrap. A design that applied them at once would wrap early, or would stretch ticks before the event. It forces updates while muted and in down mode. A wrong design would stay silent, keep counting from the old value, or restart at 0 instead of the reload value. It also checks the center-mode turn-arounds, where an off-by-one would show as a repeated end value or a misplaced pulse.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
    localparam int TBU_AW = 3;

    localparam logic [TBU_AW-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [TBU_AW-1:0] ADDR_COUNT  = 3'd1;
    localparam logic [TBU_AW-1:0] ADDR_DIV    = 3'd2;
    localparam logic [TBU_AW-1:0] ADDR_RELOAD = 3'd3;
    localparam logic [TBU_AW-1:0] ADDR_FLAG   = 3'd4;
    localparam logic [TBU_AW-1:0] ADDR_GEN    = 3'd5;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2
    } cnt_mode_t;

    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } dir_state_t;

    typedef struct packed {
        logic [1:0] mode;
        logic       buf_en;
        logic       mute;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tbu_prescaler.sv
module tbu_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         uev,
    input  logic         sw_gen,
    input  logic [W-1:0] div_buf,
    output logic         tick
);
    logic         en_q;
    logic [W-1:0] div_shadow_q;
    logic [W-1:0] div_q;

    assign tick = en_q && (div_q >= div_shadow_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q         <= 1'b0;
            div_shadow_q <= '0;
            div_q        <= '0;
        end else begin
            en_q <= run;
            if (uev) begin
                div_shadow_q <= div_buf;
            end
            if (sw_gen) begin
                div_q <= '0;
            end else if (en_q) begin
                div_q <= tick ? '0 : div_q + 1'b1;
            end
        end
    end

    a_r9_sw_clears_divider: assert property (@(posedge clk) disable iff (!rst_n)
        sw_gen |=> (div_q == '0));

endmodule

// File: rtl/tbu_counter.sv
module tbu_counter
    import tbu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  cnt_mode_t    mode,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] limit_buf,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         sw_gen,
    output logic [W-1:0] cnt_q,
    output logic         hw_evt
);
    localparam logic [W-1:0] ONE   = 1;
    localparam logic [W:0]   ONE_X = 1;

    dir_state_t   state_q, state_d;
    logic [W-1:0] cnt_d;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + ONE_X;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RISE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        cnt_d  = cnt_q;
        hw_evt = 1'b0;
        unique case (mode)
            MODE_DOWN:   state_d = ST_FALL;
            MODE_CENTER: state_d = state_q;
            default:     state_d = ST_RISE;
        endcase

        if (sw_gen) begin
            if (mode == MODE_DOWN) begin
                cnt_d   = limit_buf;
                state_d = ST_FALL;
            end else begin
                cnt_d   = '0;
                state_d = ST_RISE;
            end
        end else if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else if (tick) begin
            unique case (mode)
                MODE_DOWN: begin
                    if (cnt_q == '0) begin
                        cnt_d  = limit;
                        hw_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                MODE_CENTER: begin
                    unique case (state_q)
                        ST_RISE: begin
                            if (cnt_inc >= {1'b0, limit}) begin
                                cnt_d   = limit;
                                hw_evt  = 1'b1;
                                state_d = ST_FALL;
                            end else begin
                                cnt_d = cnt_q + ONE;
                            end
                        end
                        ST_FALL: begin
                            if (cnt_q <= ONE) begin
                                cnt_d   = '0;
                                hw_evt  = 1'b1;
                                state_d = ST_RISE;
                            end else begin
                                cnt_d = cnt_q - ONE;
                            end
                        end
                        default: cnt_d = cnt_q;
                    endcase
                end
                default: begin
                    if (cnt_q >= limit) begin
                        cnt_d  = '0;
                        hw_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            endcase
        end
    end

    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_UP && !sw_gen && !cnt_wr && cnt_q < limit)
        |=> (cnt_q == $past(cnt_q) + ONE));

    a_r4_underflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_DOWN && !sw_gen && !cnt_wr && cnt_q == '0)
        |=> (cnt_q == $past(limit)));

    a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sw_gen && !cnt_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/tbu_regs.sv
module tbu_regs
    import tbu_pkg::*;
#(
    parameter int           W           = 16,
    parameter logic [W-1:0] RELOAD_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TBU_AW-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [TBU_AW-1:0] rd_addr,
    input  logic              hw_evt,
    input  logic [W-1:0]      cnt_val,
    output logic [W-1:0]      rd_data,
    output logic              run,
    output cnt_mode_t         mode,
    output logic [W-1:0]      div_buf,
    output logic [W-1:0]      limit,
    output logic [W-1:0]      limit_buf,
    output logic              cnt_wr,
    output logic              sw_gen,
    output logic              uev,
    output logic              update_pulse,
    output logic              update_flag
);
    ctrl_t        ctrl_q;
    logic [W-1:0] div_buf_q;
    logic [W-1:0] lim_buf_q;
    logic [W-1:0] lim_shadow_q;
    logic         pulse_q;
    logic         flag_q;

    assign sw_gen = wr_en && (wr_addr == ADDR_GEN) && wr_data[0];
    assign cnt_wr = wr_en && (wr_addr == ADDR_COUNT);
    assign uev    = (hw_evt && !ctrl_q.mute) || sw_gen;

    assign run          = ctrl_q.run;
    assign mode         = cnt_mode_t'(ctrl_q.mode);
    assign div_buf      = div_buf_q;
    assign limit_buf    = lim_buf_q;
    assign limit        = ctrl_q.buf_en ? lim_shadow_q : lim_buf_q;
    assign update_pulse = pulse_q;
    assign update_flag  = flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            div_buf_q    <= '0;
            lim_buf_q    <= RELOAD_INIT;
            lim_shadow_q <= RELOAD_INIT;
            pulse_q      <= 1'b0;
            flag_q       <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    ADDR_CTRL:   ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    ADDR_DIV:    div_buf_q <= wr_data;
                    ADDR_RELOAD: lim_buf_q <= wr_data;
                    default:     ;
                endcase
            end
            if (!ctrl_q.buf_en || uev) begin
                lim_shadow_q <= lim_buf_q;
            end
            pulse_q <= uev;
            if (uev) begin
                flag_q <= 1'b1;
            end else if (wr_en && wr_addr == ADDR_FLAG) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = W'(ctrl_q);
            ADDR_COUNT:  rd_data = cnt_val;
            ADDR_DIV:    rd_data = div_buf_q;
            ADDR_RELOAD: rd_data = lim_buf_q;
            ADDR_FLAG:   rd_data = {{(W-1){1'b0}}, flag_q};
            default:     rd_data = '0;
        endcase
    end

    a_r7_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.buf_en && !uev) |=> $stable(lim_shadow_q));

    a_r8_mute_blocks_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mute && !sw_gen) |=> !pulse_q);

    a_r10_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> flag_q);

endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
    import tbu_pkg::*;
#(
    parameter int                CNT_W       = 16,
    parameter logic [CNT_W-1:0]  RELOAD_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TBU_AW-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [TBU_AW-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  count_val,
    output logic              update_pulse,
    output logic              update_flag
);
    logic             run;
    cnt_mode_t        mode;
    logic [CNT_W-1:0] div_buf;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] limit_buf;
    logic             cnt_wr;
    logic             sw_gen;
    logic             uev;
    logic             tick;
    logic             hw_evt;
    logic [CNT_W-1:0] cnt_q;

    assign count_val = cnt_q;

    tbu_regs #(.W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .hw_evt       (hw_evt),
        .cnt_val      (cnt_q),
        .rd_data      (rd_data),
        .run          (run),
        .mode         (mode),
        .div_buf      (div_buf),
        .limit        (limit),
        .limit_buf    (limit_buf),
        .cnt_wr       (cnt_wr),
        .sw_gen       (sw_gen),
        .uev          (uev),
        .update_pulse (update_pulse),
        .update_flag  (update_flag)
    );

    tbu_prescaler #(.W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .uev     (uev),
        .sw_gen  (sw_gen),
        .div_buf (div_buf),
        .tick    (tick)
    );

    tbu_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .limit     (limit),
        .limit_buf (limit_buf),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data),
        .sw_gen    (sw_gen),
        .cnt_q     (cnt_q),
        .hw_evt    (hw_evt)
    );

endmodule

// File: tb/tbu_timebase_test.sv
`timescale 1ns/1ps
module tbu_timebase_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] count_val;
    logic        update_pulse;
    logic        update_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          at;
        logic [15:0] cnt;
        logic        pulse;
        logic        flag;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    tbu_timebase uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .count_val(count_val), .update_pulse(update_pulse),
        .update_flag(update_flag)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares queued expectations in the cycle they target
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (count_val !== e.cnt || update_pulse !== e.pulse || update_flag !== e.flag) begin
                n_bad++;
                $display("FAIL %s cyc=%0d: count=%0d pulse=%b flag=%b expected count=%0d pulse=%b flag=%b",
                         e.tag, cyc, count_val, update_pulse, update_flag, e.cnt, e.pulse, e.flag);
            end
        end
    end

    task automatic expect_in(input int k, input logic [15:0] c, input logic p,
                             input logic f, input string tag);
        exp_t e;
        e.at = cyc + k;
        e.cnt = c;
        e.pulse = p;
        e.flag = f;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string tag);
        rd_addr = a;
        #1;
        n_cmp++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s read addr %0d: got %0h expected %0h", tag, a, rd_data, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                n_bad++;
                $display("FAIL %s: expectation never compared, expected count=%0d", e.tag, e.cnt);
            end
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_in(1, 16'd0, 1'b0, 1'b0, "R1");
        step(2);
        rd_chk(3'd3, 16'hFFFF, "R1");
        rd_chk(3'd2, 16'h0000, "R1");
        rd_chk(3'd4, 16'h0000, "R1");

        // R7 (buffer off): new limit used at once
        wr(3'd3, 16'd3);
        rd_chk(3'd3, 16'd3, "R11");

        // R2 enable lag, R3 up counting period
        expect_in(1, 0, 0, 0, "R2");
        expect_in(2, 0, 0, 0, "R2");
        expect_in(3, 1, 0, 0, "R2");
        expect_in(4, 2, 0, 0, "R3");
        expect_in(5, 3, 0, 0, "R3");
        expect_in(6, 0, 1, 1, "R3");
        expect_in(7, 1, 0, 1, "R3");
        wr(3'd0, 16'h0001);
        rd_chk(3'd0, 16'h0001, "R11");
        step(6);

        // R10 flag clear by write, then set again
        expect_in(1, 2, 0, 0, "R10");
        expect_in(2, 3, 0, 0, "R10");
        expect_in(3, 0, 1, 1, "R10");
        wr(3'd4, 16'h0000);
        step(2);

        // R8 muted wrap
        expect_in(2, 2, 0, 0, "R8");
        expect_in(3, 3, 0, 0, "R8");
        expect_in(4, 0, 0, 0, "R8");
        expect_in(5, 1, 0, 0, "R8");
        wr(3'd0, 16'h0003);
        wr(3'd4, 16'h0000);
        step(3);

        // R9 forced update while muted
        expect_in(1, 0, 1, 1, "R9");
        expect_in(2, 1, 0, 1, "R9");
        expect_in(3, 2, 0, 1, "R9");
        wr(3'd5, 16'h0001);
        step(2);

        // R11 count write while running
        expect_in(1, 0, 0, 1, "R11");
        expect_in(2, 1, 0, 1, "R11");
        wr(3'd1, 16'h0000);
        step(1);

        // unmute, clear flag, wrap
        expect_in(2, 3, 0, 0, "R3");
        expect_in(3, 0, 1, 1, "R3");
        wr(3'd0, 16'h0001);
        wr(3'd4, 16'h0000);
        step(1);

        // R6 divider ratio buffered until update
        expect_in(1, 1, 0, 1, "R6");
        expect_in(2, 2, 0, 1, "R6");
        expect_in(3, 3, 0, 1, "R6");
        expect_in(4, 0, 1, 1, "R6");
        expect_in(5, 0, 0, 1, "R6");
        expect_in(6, 1, 0, 1, "R6");
        expect_in(7, 1, 0, 1, "R6");
        expect_in(8, 2, 0, 1, "R6");
        wr(3'd2, 16'h0001);
        step(7);

        // restore ratio 1 via forced update (R9 clears divider)
        expect_in(1, 2, 0, 1, "R6");
        expect_in(2, 0, 1, 1, "R9");
        expect_in(3, 1, 0, 1, "R6");
        wr(3'd2, 16'h0000);
        wr(3'd5, 16'h0001);
        step(1);

        // R7 buffered limit applies only after update
        expect_in(1, 2, 0, 1, "R7");
        expect_in(2, 3, 0, 1, "R7");
        expect_in(3, 0, 1, 1, "R7");
        expect_in(4, 1, 0, 1, "R7");
        expect_in(9, 6, 0, 1, "R7");
        expect_in(10, 0, 1, 1, "R7");
        wr(3'd0, 16'h0005);
        wr(3'd3, 16'd6);
        step(8);

        // R4 down counting
        expect_in(1, 1, 0, 1, "R4");
        expect_in(2, 0, 0, 1, "R4");
        expect_in(3, 6, 1, 1, "R4");
        expect_in(4, 5, 0, 1, "R4");
        wr(3'd0, 16'h000D);
        step(3);

        // R9 forced update in down mode reloads
        expect_in(1, 6, 1, 1, "R9");
        expect_in(2, 5, 0, 1, "R9");
        wr(3'd5, 16'h0001);
        step(1);

        // R5 center-aligned with limit 3
        expect_in(1, 4, 0, 1, "R5");
        expect_in(2, 3, 0, 1, "R5");
        expect_in(3, 0, 1, 1, "R9");
        expect_in(4, 1, 0, 1, "R5");
        expect_in(5, 2, 0, 1, "R5");
        expect_in(6, 3, 1, 1, "R5");
        expect_in(7, 2, 0, 1, "R5");
        expect_in(8, 1, 0, 1, "R5");
        expect_in(9, 0, 1, 1, "R5");
        expect_in(10, 1, 0, 1, "R5");
        expect_in(11, 2, 0, 1, "R5");
        wr(3'd3, 16'd3);
        wr(3'd0, 16'h0015);
        wr(3'd5, 16'h0001);
        step(8);

        // R12 stop after enable lag
        expect_in(1, 3, 1, 1, "R12");
        expect_in(2, 2, 0, 1, "R12");
        expect_in(3, 2, 0, 1, "R12");
        expect_in(4, 2, 0, 1, "R12");
        wr(3'd0, 16'h0014);
        step(3);
        rd_chk(3'd1, 16'd2, "R11");
        rd_chk(3'd3, 16'd3, "R11");
        rd_chk(3'd0, 16'h0014, "R11");
        rd_chk(3'd4, 16'h0001, "R10");
        step(2);
        finish_run();
    end
endmodule